// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

This block sits beside the once-per-second update path of a real-time clock. On every update tick it looks at the time and calendar fields that are about to be advanced. It decides whether the normal increment should be replaced by a daylight-saving correction. When a correction applies, it raises an override strobe for that tick and presents the replacement hour, minute, second and PM values. The surrounding update logic then loads these values instead of the incremented ones.

Two corrections exist, and both fire only when the adjuster is enabled:

- **Spring.** On the first Sunday of April the clock jumps from 1:59:59 AM straight to 3:00:00 AM.
- **Fall.** On the last Sunday of October the clock steps from 1:59:59 AM back to 1:00:00 AM.

The fall correction is taken only once per night. A flag is set when the fall-back fires, so the repeated hour runs through normally. All fields may be BCD or binary, and the hour may be in 12-hour or 24-hour form. Detection honours whichever encoding is active.

Top module: `dst_adjuster`

## Requirements
- R1: When `dstEn` is 0, `ovrStrobe` stays 0 whatever the time fields hold.
- R2: Spring case. `ovrStrobe` is 1 in the tick cycle when month is 4, `dowIn` is 1 (Sunday), date is 1 to 7 and the time is 1:59:59 AM. In that cycle the outputs give hour 3, PM 0, minute 0 and second 0.
- R3: Fall case. `ovrStrobe` is 1 in the tick cycle when month is 10, `dowIn` is 1 (Sunday), date is 25 to 31 and the time is 1:59:59 AM, provided the fall-done flag is clear. In that cycle the outputs give hour 1, PM 0, minute 0 and second 0.
- R4: A fall-back sets an internal flag. While the flag is set, another 1:59:59 AM on that October Sunday does not raise `ovrStrobe`.
- R5: The flag is cleared by a tick whose time is 3 AM, or by a tick whose raw date field differs from the date of the previous tick. The clear acts from the following tick onward.
- R6: With `binMode` 0 every field is read as two BCD digits (59 is 0x59). With `binMode` 1 every field is read as a plain binary value (59 is 0x3B). A value that is correct only in the other encoding does not match.
- R7: With `hr24` 0, 1 AM means hour 1 with `pmIn` 0, and `pmIn` 1 blocks detection. With `hr24` 1, 1 AM means hour 1 regardless of `pmIn`, and hour 13 does not match.
- R8: `ovrStrobe` is 1 only in a cycle with `updTick` high. Whenever `ovrStrobe` is 0, `ovrHour`, `ovrMin`, `ovrSec` and `ovrPm` are all 0.
- R9: The replacement minute and second are always 0, and the replacement PM bit is always 0.
- R10: A Sunday outside the date window does not match. Examples are April 8 and October 24.
- R11: `rstN` low clears the fall-done flag, so a fall-back may fire again after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| updTick | input | 1 | One-cycle once-per-second update tick |
| dstEn | input | 1 | Daylight-saving enable |
| binMode | input | 1 | 0 = BCD fields, 1 = binary fields |
| hr24 | input | 1 | 0 = 12-hour, 1 = 24-hour |
| secIn | input | 8 | Current seconds |
| minIn | input | 8 | Current minutes |
| hourIn | input | 8 | Current hour, without the PM indicator |
| pmIn | input | 1 | PM indicator (12-hour mode) |
| dowIn | input | 3 | Day of week, 1 = Sunday to 7 |
| dateIn | input | 8 | Day of month |
| monthIn | input | 8 | Month |
| ovrStrobe | output | 1 | Replace the normal increment this tick |
| ovrHour | output | 8 | Replacement hour |
| ovrPm | output | 1 | Replacement PM indicator |
| ovrMin | output | 8 | Replacement minutes |
| ovrSec | output | 8 | Replacement seconds |

## Verification
The assertions check the following on every clock:

- The spring and fall selections are never active together.
- The fall selection always leaves the flag set.
- The strobe never appears without an enabled tick.
- The replacement hour, minute, second and PM values agree with the selection that is active.

Some behaviour can only be shown by the bench scenarios, which run against a behavioural model:

- Which calendar and time combinations match in each encoding and hour format.
- The window edges.
- That the repeated hour in fall runs through normally.
- That the flag is released by 3 AM, by a date change or by reset.

// File: rtl/dst_pkg.sv
`timescale 1ns/1ps
package dst_pkg;
  localparam int FIELD_W = 8;
  localparam int DOW_W   = 3;

  // Calendar and time conditions decoded by the datapath
  typedef struct packed {
    logic springHit;
    logic fallHit;
    logic threeAm;
  } dstMatchT;

  // Strobes from control to datapath
  typedef struct packed {
    logic selSpring;
    logic selFall;
    logic strobe;
  } dstCtrlT;
endpackage

// File: rtl/dst_datapath.sv
`timescale 1ns/1ps
module dst_datapath
  import dst_pkg::*;
#(
  parameter int FW           = FIELD_W,
  parameter int DW           = DOW_W,
  parameter int SUNDAY_CODE  = 1,
  parameter int SPRING_MONTH = 4,
  parameter int FALL_MONTH   = 10,
  parameter int WEEK_LEN     = 7,
  parameter int MONTH_DAYS   = 31,
  parameter int SKIP_HOUR    = 1,
  parameter int LAND_HOUR    = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          binMode,
  input  logic          hr24,
  input  logic [FW-1:0] secIn,
  input  logic [FW-1:0] minIn,
  input  logic [FW-1:0] hourIn,
  input  logic          pmIn,
  input  logic [DW-1:0] dowIn,
  input  logic [FW-1:0] dateIn,
  input  logic [FW-1:0] monthIn,
  input  dstCtrlT       ctrl,
  output dstMatchT      match,
  output logic [FW-1:0] ovrHour,
  output logic [FW-1:0] ovrMin,
  output logic [FW-1:0] ovrSec,
  output logic          ovrPm
);
  localparam int NF         = 5;
  localparam int LAST_START = MONTH_DAYS - WEEK_LEN + 1;
  localparam int MAX_VAL    = 59;

  logic [FW-1:0] rawF [NF];
  logic [FW-1:0] binF [NF];

  assign rawF[0] = secIn;
  assign rawF[1] = minIn;
  assign rawF[2] = hourIn;
  assign rawF[3] = dateIn;
  assign rawF[4] = monthIn;

  // Each field is decoded into binary according to the active data mode
  for (genvar i = 0; i < NF; i++) begin : g_dec
    logic [FW-1:0] hiNib, loNib;
    assign hiNib   = rawF[i] >> 4;
    assign loNib   = rawF[i] & FW'(15);
    assign binF[i] = binMode ? rawF[i] : (hiNib * FW'(10) + loNib);
  end

  logic lastSec, isSunday, amHourSkip, amHourLand;
  logic inFirstWeek, inLastWeek;

  function automatic logic hourIsAm(input logic [FW-1:0] h, input int n,
                                    input logic is24, input logic pm);
    return (h == FW'(n)) && (is24 || !pm);
  endfunction

  always_comb begin
    lastSec     = (binF[0] == FW'(MAX_VAL)) && (binF[1] == FW'(MAX_VAL));
    isSunday    = (dowIn == DW'(SUNDAY_CODE));
    amHourSkip  = hourIsAm(binF[2], SKIP_HOUR, hr24, pmIn);
    amHourLand  = hourIsAm(binF[2], LAND_HOUR, hr24, pmIn);
    inFirstWeek = (binF[3] >= FW'(1)) && (binF[3] <= FW'(WEEK_LEN));
    inLastWeek  = (binF[3] >= FW'(LAST_START)) && (binF[3] <= FW'(MONTH_DAYS));

    match.springHit = isSunday && inFirstWeek && (binF[4] == FW'(SPRING_MONTH))
                      && amHourSkip && lastSec;
    match.fallHit   = isSunday && inLastWeek && (binF[4] == FW'(FALL_MONTH))
                      && amHourSkip && lastSec;
    match.threeAm   = amHourLand;
  end

  // Small hour values are identical in BCD and binary, so no re-encode is needed
  always_comb begin
    ovrHour = '0;
    ovrMin  = '0;
    ovrSec  = '0;
    ovrPm   = 1'b0;
    if (ctrl.selSpring)   ovrHour = FW'(LAND_HOUR);
    else if (ctrl.selFall) ovrHour = FW'(SKIP_HOUR);
  end

  p_spring_hour_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.selSpring |-> (ovrHour == FW'(LAND_HOUR)));
  p_fall_hour_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.selFall |-> (ovrHour == FW'(SKIP_HOUR)));
  p_zero_minsec_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.strobe |-> (ovrMin == '0 && ovrSec == '0 && !ovrPm));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.strobe |-> (ovrHour == '0));
endmodule

// File: rtl/dst_control.sv
`timescale 1ns/1ps
module dst_control
  import dst_pkg::*;
#(
  parameter int FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          updTick,
  input  logic          dstEn,
  input  dstMatchT      match,
  input  logic [FW-1:0] dateRaw,
  output dstCtrlT       ctrl
);
  logic          fallDone;
  logic [FW-1:0] lastDate;

  always_comb begin
    ctrl.selSpring = updTick && dstEn && match.springHit;
    ctrl.selFall   = updTick && dstEn && match.fallHit && !fallDone;
    ctrl.strobe    = ctrl.selSpring || ctrl.selFall;
  end

  // The one-shot flag is released by 3 AM or by a new date
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallDone <= 1'b0;
      lastDate <= '0;
    end else if (updTick) begin
      if (ctrl.selFall)
        fallDone <= 1'b1;
      else if (match.threeAm || (dateRaw != lastDate))
        fallDone <= 1'b0;
      lastDate <= dateRaw;
    end
  end

  p_single_sel_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.selSpring, ctrl.selFall}));
  p_flag_after_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.selFall |=> fallDone);
  p_tick_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!updTick || !dstEn) |-> !ctrl.strobe);
endmodule

// File: rtl/dst_adjuster.sv
`timescale 1ns/1ps
module dst_adjuster
  import dst_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int DW = DOW_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          updTick,
  input  logic          dstEn,
  input  logic          binMode,
  input  logic          hr24,
  input  logic [FW-1:0] secIn,
  input  logic [FW-1:0] minIn,
  input  logic [FW-1:0] hourIn,
  input  logic          pmIn,
  input  logic [DW-1:0] dowIn,
  input  logic [FW-1:0] dateIn,
  input  logic [FW-1:0] monthIn,
  output logic          ovrStrobe,
  output logic [FW-1:0] ovrHour,
  output logic          ovrPm,
  output logic [FW-1:0] ovrMin,
  output logic [FW-1:0] ovrSec
);
  dstMatchT match;
  dstCtrlT  ctrl;

  dst_datapath #(.FW(FW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .binMode(binMode), .hr24(hr24),
    .secIn(secIn), .minIn(minIn), .hourIn(hourIn), .pmIn(pmIn),
    .dowIn(dowIn), .dateIn(dateIn), .monthIn(monthIn), .ctrl(ctrl),
    .match(match), .ovrHour(ovrHour), .ovrMin(ovrMin), .ovrSec(ovrSec),
    .ovrPm(ovrPm)
  );

  dst_control #(.FW(FW)) u_ctl (
    .clk(clk), .rstN(rstN), .updTick(updTick), .dstEn(dstEn),
    .match(match), .dateRaw(dateIn), .ctrl(ctrl)
  );

  assign ovrStrobe = ctrl.strobe;
endmodule

// File: tb/tb_dst_adjuster.sv
`timescale 1ns/1ps
module tb_dst_adjuster;
  logic clk = 0, rstN = 0, updTick = 0, dstEn = 0, binMode = 0, hr24 = 0, pmIn = 0;
  logic [7:0] secIn = 0, minIn = 0, hourIn = 0, dateIn = 0, monthIn = 0;
  logic [2:0] dowIn = 0;
  logic ovrStrobe, ovrPm;
  logic [7:0] ovrHour, ovrMin, ovrSec;

  int compared = 0, mismatched = 0;
  bit mFlag = 0;
  logic [7:0] mLast = 0;

  always #5 clk = ~clk;

  dst_adjuster dut (.*);

  function automatic int dec(input logic [7:0] v);
    return binMode ? int'(v) : int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] enc(input int v);
    return binMode ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic bit isAm(input int n);
    return dec(hourIn) == n && (hr24 || !pmIn);
  endfunction

  task automatic step(input string tag, input bit tk, input logic [7:0] h,
                      input logic [7:0] m, input logic [7:0] s, input bit pm,
                      input int dw, input logic [7:0] dt, input logic [7:0] mo);
    bit base, sp, fa, exS;
    int exH;
    updTick = tk; hourIn = h; minIn = m; secIn = s; pmIn = pm;
    dowIn = 3'(dw); dateIn = dt; monthIn = mo;
    #1;
    base = tk && dstEn && dowIn == 1 && isAm(1) && dec(minIn) == 59 && dec(secIn) == 59;
    sp   = base && dec(monthIn) == 4 && dec(dateIn) >= 1 && dec(dateIn) <= 7;
    fa   = base && !mFlag && dec(monthIn) == 10 && dec(dateIn) >= 25 && dec(dateIn) <= 31;
    exS  = sp || fa;
    exH  = sp ? 3 : (fa ? 1 : 0);
    compared++;
    if (ovrStrobe !== exS || ovrHour !== 8'(exH) || ovrMin !== 0 || ovrSec !== 0 || ovrPm !== 0) begin
      mismatched++;
      $display("FAIL %s: got strobe=%0b hour=%0h min=%0h sec=%0h pm=%0b, expected strobe=%0b hour=%0h min=0 sec=0 pm=0",
               tag, ovrStrobe, ovrHour, ovrMin, ovrSec, ovrPm, exS, exH);
    end
    @(posedge clk);
    if (rstN && tk) begin
      if (fa) mFlag = 1;
      else if (isAm(3) || dateIn != mLast) mFlag = 0;
      mLast = dateIn;
    end
    @(negedge clk);
    updTick = 0;
  endtask

  task automatic doReset();
    rstN = 0; mFlag = 0; mLast = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    dstEn = 1;
    step("R8 reset idle", 0, 0, 0, 0, 0, 0, 0, 0);
    for (int b = 0; b < 2; b++) begin
      for (int f = 0; f < 2; f++) begin
        binMode = b[0]; hr24 = f[0];
        // R2 spring window and edges (R10)
        step("R2 april d1", 1, enc(1), enc(59), enc(59), 0, 1, enc(1), enc(4));
        step("R2 april d7", 1, enc(1), enc(59), enc(59), 0, 1, enc(7), enc(4));
        step("R10 april d8", 1, enc(1), enc(59), enc(59), 0, 1, enc(8), enc(4));
        step("R2 monday", 1, enc(1), enc(59), enc(59), 0, 2, enc(2), enc(4));
        step("R2 sec58", 1, enc(1), enc(59), enc(58), 0, 1, enc(2), enc(4));
        step("R7 pm set", 1, enc(1), enc(59), enc(59), 1, 1, enc(3), enc(4));
        step("R7 hour13", 1, enc(13), enc(59), enc(59), 0, 1, enc(3), enc(4));
        step("R8 no tick", 0, enc(1), enc(59), enc(59), 0, 1, enc(3), enc(4));
        dstEn = 0;
        step("R1 disabled", 1, enc(1), enc(59), enc(59), 0, 1, enc(3), enc(4));
        dstEn = 1;
        // R6 wrong-encoding value for 59
        step("R6 cross enc", 1, enc(1), b ? 8'h59 : 8'h3B, enc(59), 0, 1, enc(3), enc(4));
        // R3/R4/R5 fall sequence
        step("R10 oct d24", 1, enc(1), enc(59), enc(59), 0, 1, enc(24), enc(10));
        step("R3 fall d31", 1, enc(1), enc(59), enc(59), 0, 1, enc(31), enc(10));
        step("R4 mid hour", 1, enc(1), enc(30), enc(0), 0, 1, enc(31), enc(10));
        step("R4 repeat", 1, enc(1), enc(59), enc(59), 0, 1, enc(31), enc(10));
        step("R5 3am", 1, enc(3), enc(0), enc(0), 0, 1, enc(31), enc(10));
        step("R5 after 3am", 1, enc(1), enc(59), enc(59), 0, 1, enc(31), enc(10));
        step("R5 new date", 1, enc(1), enc(59), enc(59), 0, 1, enc(25), enc(10));
        step("R5 after date", 1, enc(1), enc(59), enc(59), 0, 1, enc(25), enc(10));
        step("R4 blocked", 1, enc(1), enc(59), enc(59), 0, 1, enc(25), enc(10));
        doReset();
        step("R11 after reset", 1, enc(1), enc(59), enc(59), 0, 1, enc(25), enc(10));
        step("R9 spring zero", 1, enc(1), enc(59), enc(59), 0, 1, enc(5), enc(4));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule